// File: doc/BRIEF.md
# Segment Descriptor Fetch Unit

This unit turns a segment selector into an unpacked segment descriptor. It keeps a table register: a linear base address and a 16-bit size, where the size is the table length in bytes minus one. A load command writes this register. When a selector arrives, the unit takes the table index from the selector and rejects the null entry and any entry outside the table. It then reads the 8-byte entry through a 64-bit valid/ready memory port, checks the present bit and the system type, and gathers the scattered base, limit, access and flag fields.

Two cases need extra memory traffic. A code or data entry whose accessed bit is clear is written back with that bit set. In long mode, an LDT or TSS descriptor fills two consecutive entries, so the unit reads a second word to get the upper half of the base. Every request ends in a one-cycle done pulse carrying a fault code. When the code is none, the descriptor outputs are valid.

Top module: `seg_desc_fetch`

## Requirements
- R1: After reset the unit is idle:
  - `req_ready` is 1.
  - `mem_valid` is 0.
  - `done` is 0.
- R2: Loading the table register:
  - While `tbl_load` is high, a clock edge captures the base and the size.
  - The index is `req_sel[15:3]`. `req_sel[2:0]` has no effect on the result.
  - Entry n is read at table base + 8·n.
- R3: An index of 0 ends the request with fault code 1 (null). It makes no memory access.
- R4: An index n with 8·n+7 greater than the size ends the request with fault code 2 (bounds), with no memory access. For a two-entry descriptor, 8·n+15 greater than the size also ends it with fault code 2, after the first read.
- R5: The descriptor fields are gathered from the 64-bit entry e:
  - base[31:0] = {e[63:56], e[39:32], e[31:16]}
  - limit = {e[51:48], e[15:0]}
  - access = e[47:40]
  - flags = e[55:52]
- R6: If access bit 7 (present) is 0, the request ends with fault code 3 (not present). This check comes before the type check.
- R7: When access bit 4 is 0 (system entry), access[3:0] must be a valid type, otherwise the request ends with fault code 4 (bad type).
  - Outside long mode the valid types are 1, 2, 3, 9 and 0xB.
  - In long mode (`req_long` high) the valid types are 2, 9 and 0xB.
  - Code and data entries are never rejected on type.
- R8: A long-mode system entry n also reads entry n+1 at base + 8·(n+1). Bits 31:0 of that word become base[63:32]. In every other case base[63:32] is 0.
- R9: The accessed bit:
  - A code or data entry with access bit 0 clear is written back to the same address with entry bit 40 set. The reported access byte then has bit 0 set.
  - Entries with the bit already set, and system entries, cause no write.
- R10: If `mem_err` is high during the write-back handshake, the request ends with fault code 5 (write failed).
- R11: `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` stay stable until `mem_ready`. Read data is taken in the cycle where `mem_valid` and `mem_ready` are both high.
- R12: Request completion:
  - `done` is a one-cycle pulse.
  - `fault` is 0 for success and never above 5.
  - `req_ready` is high only when the unit is idle, and then `mem_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_load | input | 1 | Write the table register |
| tbl_base_in | input | AW | Table linear base address |
| tbl_size_in | input | 16 | Table length in bytes minus one |
| req_valid | input | 1 | Selector request |
| req_ready | output | 1 | Unit idle, request accepted |
| req_sel | input | 16 | Selector, index in bits 15:3 |
| req_long | input | 1 | Long mode in effect |
| mem_valid | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the 64-bit word |
| mem_wdata | output | 64 | Write data |
| mem_ready | input | 1 | Memory accepts the access, read data valid |
| mem_rdata | input | 64 | Read data |
| mem_err | input | 1 | Write refused |
| done | output | 1 | Request finished |
| fault | output | 3 | 0 none, 1 null, 2 bounds, 3 not present, 4 bad type, 5 write failed |
| seg_base | output | 64 | Descriptor base |
| seg_limit | output | 20 | Descriptor limit (raw) |
| seg_access | output | 8 | Access byte |
| seg_flags | output | 4 | Flags nibble |

## Verification
The assertions check the following on every cycle:
- the memory request stays stable until it is accepted;
- the done pulse lasts one cycle;
- the idle state and memory traffic never overlap;
- every write-back carries the accessed bit;
- a successful result never comes from index 0;
- a write-failed code always follows a refused write.

Only the bench scenarios can show the rest:
- that the gathered base, limit, access and flags match the entry contents;
- that the type rules differ between long and legacy mode;
- that the second word of a system entry comes from the next address and the table-edge bounds hold;
- that the memory contents after a write-back are correct.

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tbl_load,
  input  logic [AW-1:0] tbl_base_in,
  input  logic [15:0]   tbl_size_in,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [15:0]   req_sel,
  input  logic          req_long,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic [63:0]   mem_rdata,
  input  logic          mem_err,
  output logic          done,
  output logic [2:0]    fault,
  output logic [63:0]   seg_base,
  output logic [19:0]   seg_limit,
  output logic [7:0]    seg_access,
  output logic [3:0]    seg_flags
);
  localparam logic [2:0] F_NONE = 3'd0, F_NULL = 3'd1, F_BOUNDS = 3'd2,
                         F_NP = 3'd3, F_TYPE = 3'd4, F_WFAIL = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_WB} st_t;
  st_t st;

  logic [AW-1:0] tb_base;
  logic [15:0]   tb_size;
  logic [12:0]   idx_q;
  logic          long_q;
  logic [63:0]   lo_q;
  logic [31:0]   hi_q;

  wire [12:0] idx_in  = req_sel[15:3];
  wire        oob_one = {1'b0, idx_in, 3'b111} > {1'b0, tb_size};
  wire        oob_two = ({1'b0, idx_q, 3'b000} + 17'd15) > {1'b0, tb_size};
  wire        fire    = mem_valid && mem_ready;

  wire [7:0] acc_rd  = mem_rdata[47:40];
  wire       sys_rd  = !acc_rd[4];
  wire [3:0] ty_rd   = acc_rd[3:0];
  wire       ty_long = (ty_rd == 4'h2) || (ty_rd == 4'h9) || (ty_rd == 4'hB);
  wire       ty_leg  = ty_long || (ty_rd == 4'h1) || (ty_rd == 4'h3);
  wire       type_ok = !sys_rd || (long_q ? ty_long : ty_leg);
  wire       pair_rd = sys_rd && long_q;
  wire       wb_rd   = !sys_rd && !acc_rd[0];

  assign req_ready = (st == S_IDLE);
  assign mem_valid = (st != S_IDLE);
  assign mem_we    = (st == S_WB);
  assign mem_wdata = lo_q;
  assign mem_addr  = tb_base + AW'({idx_q, 3'b000}) + ((st == S_HI) ? AW'(8) : AW'(0));

  assign seg_base   = {hi_q, lo_q[63:56], lo_q[39:32], lo_q[31:16]};
  assign seg_limit  = {lo_q[51:48], lo_q[15:0]};
  assign seg_access = lo_q[47:40];
  assign seg_flags  = lo_q[55:52];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      done    <= 1'b0;
      fault   <= F_NONE;
      tb_base <= '0;
      tb_size <= '0;
      idx_q   <= '0;
      long_q  <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      done <= 1'b0;
      if (tbl_load) begin
        tb_base <= tbl_base_in;
        tb_size <= tbl_size_in;
      end
      case (st)
        S_IDLE: if (req_valid) begin
          idx_q  <= idx_in;
          long_q <= req_long;
          hi_q   <= '0;
          if (idx_in == '0) begin
            done <= 1'b1; fault <= F_NULL;
          end else if (oob_one) begin
            done <= 1'b1; fault <= F_BOUNDS;
          end else begin
            st <= S_LO;
          end
        end
        S_LO: if (fire) begin
          lo_q <= mem_rdata | (wb_rd ? (64'h1 << 40) : 64'h0);
          if (!acc_rd[7]) begin
            done <= 1'b1; fault <= F_NP; st <= S_IDLE;
          end else if (!type_ok) begin
            done <= 1'b1; fault <= F_TYPE; st <= S_IDLE;
          end else if (pair_rd) begin
            if (oob_two) begin
              done <= 1'b1; fault <= F_BOUNDS; st <= S_IDLE;
            end else begin
              st <= S_HI;
            end
          end else if (wb_rd) begin
            st <= S_WB;
          end else begin
            done <= 1'b1; fault <= F_NONE; st <= S_IDLE;
          end
        end
        S_HI: if (fire) begin
          hi_q <= mem_rdata[31:0];
          done <= 1'b1; fault <= F_NONE; st <= S_IDLE;
        end
        S_WB: if (fire) begin
          done <= 1'b1; fault <= mem_err ? F_WFAIL : F_NONE; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module seg_desc_fetch_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [15:0]   req_sel,
  input logic          mem_valid,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [63:0]   mem_wdata,
  input logic          mem_ready,
  input logic          mem_err,
  input logic          done,
  input logic [2:0]    fault
);
  logic [15:0] sel_q;
  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= '0;
    else if (req_valid && req_ready) sel_q <= req_sel;
  end

  // R11
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));
  // R12
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !mem_valid);
  // R12
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> fault <= 3'd5);
  // R9
  wb_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> mem_wdata[40] && mem_wdata[44]);
  // R3
  null_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault == 3'd0 |-> sel_q[15:3] != 13'd0);
  // R10
  wfail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault == 3'd5 |-> $past(mem_valid && mem_we && mem_ready && mem_err));
endmodule

bind seg_desc_fetch seg_desc_fetch_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_sel(req_sel), .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_err(mem_err),
  .done(done), .fault(fault)
);

// File: tb/tb_seg_desc_fetch.sv
`timescale 1ns/1ps
module tb_seg_desc_fetch;
  localparam int AW = 32;
  localparam logic [31:0] TBASE = 32'h1000;

  logic clk = 0, rst_n = 0;
  logic tbl_load = 0, req_valid = 0, req_long = 0;
  logic [AW-1:0] tbl_base_in = '0;
  logic [15:0] tbl_size_in = '0, req_sel = '0;
  logic mem_ready = 0, mem_err = 0;
  logic [63:0] mem_rdata = '0;
  logic req_ready, mem_valid, mem_we, done;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_wdata, seg_base;
  logic [2:0] fault;
  logic [19:0] seg_limit;
  logic [7:0] seg_access;
  logic [3:0] seg_flags;

  always #2.5 clk = ~clk;

  seg_desc_fetch #(.AW(AW)) dut (.*);

  int checks = 0, errors = 0;
  int rd_cnt = 0, wr_cnt = 0, stall_n = 0;
  logic refuse = 0;
  logic [31:0] rd_addr [2];
  logic [63:0] mem [32];

  function automatic logic [63:0] mk(logic [31:0] b, logic [19:0] l, logic [7:0] a, logic [3:0] f);
    return {b[31:24], f, l[19:16], a, b[23:16], b[15:0], l[15:0]};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    int cnt = 0;
    for (int i = 0; i < 32; i++) mem[i] = '0;
    mem[1]  = mk(32'h12345678, 20'hABCDE, 8'h9B, 4'hC);
    mem[2]  = mk(32'hCAFEBABE, 20'h0F0F0, 8'h92, 4'h4);
    mem[3]  = mk(32'h0, 20'hFFFFF, 8'h00, 4'h0);
    mem[4]  = mk(32'h00010000, 20'h00067, 8'h81, 4'h0);
    mem[5]  = mk(32'h0, 20'h0, 8'h80, 4'h0);
    mem[6]  = mk(32'h11223344, 20'h00067, 8'h89, 4'h0);
    mem[7]  = 64'hDEADBEEF_55667788;
    mem[8]  = mk(32'h00ABCDEF, 20'h00010, 8'h92, 4'h4);
    mem[15] = mk(32'h00400000, 20'h000FF, 8'h82, 4'h0);
    forever begin
      @(negedge clk);
      mem_ready = 0;
      mem_err = 0;
      if (mem_valid) begin
        if (cnt >= stall_n) begin
          logic [4:0] w;
          w = 5'((mem_addr - TBASE) >> 3);
          mem_ready = 1;
          mem_rdata = mem[w];
          cnt = 0;
          if (mem_we) begin
            mem_err = refuse;
            if (!refuse) begin mem[w] = mem_wdata; wr_cnt++; end
          end else begin
            if (rd_cnt < 2) rd_addr[rd_cnt] = mem_addr;
            rd_cnt++;
          end
        end else cnt++;
      end else cnt = 0;
    end
  end

  logic [2:0] r_flt;
  logic [63:0] r_base;
  logic [19:0] r_lim;
  logic [7:0] r_acc;
  logic [3:0] r_flg;

  task automatic run(logic [15:0] sel, logic lng);
    int t = 0;
    rd_cnt = 0;
    @(negedge clk);
    req_valid = 1; req_sel = sel; req_long = lng;
    @(negedge clk);
    req_valid = 0;
    while (!done && t < 100) begin @(negedge clk); t++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL R12: actual no done expected done (sel %h)", sel);
    end
    r_flt = fault; r_base = seg_base; r_lim = seg_limit; r_acc = seg_access; r_flg = seg_flags;
  endtask

  task automatic load_tbl(logic [31:0] b, logic [15:0] s);
    @(negedge clk);
    tbl_load = 1; tbl_base_in = b; tbl_size_in = s;
    @(negedge clk);
    tbl_load = 0;
  endtask

  typedef struct packed {
    logic [15:0] sel; logic lng; logic [2:0] flt; logic [1:0] nrd;
    logic [63:0] base; logic [19:0] lim; logic [7:0] acc; logic [3:0] flg;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{16'h0008, 1'b0, 3'd0, 2'd1, 64'h12345678, 20'hABCDE, 8'h9B, 4'hC},
    '{16'h0000, 1'b0, 3'd1, 2'd0, 64'h0, 20'h0, 8'h0, 4'h0},
    '{16'h0010, 1'b0, 3'd0, 2'd1, 64'hCAFEBABE, 20'h0F0F0, 8'h93, 4'h4},
    '{16'h0018, 1'b0, 3'd3, 2'd1, 64'h0, 20'h0, 8'h0, 4'h0},
    '{16'h0020, 1'b0, 3'd0, 2'd1, 64'h00010000, 20'h00067, 8'h81, 4'h0},
    '{16'h0020, 1'b1, 3'd4, 2'd1, 64'h0, 20'h0, 8'h0, 4'h0},
    '{16'h0028, 1'b0, 3'd4, 2'd1, 64'h0, 20'h0, 8'h0, 4'h0},
    '{16'h0030, 1'b1, 3'd0, 2'd2, 64'h55667788_11223344, 20'h00067, 8'h89, 4'h0},
    '{16'h0030, 1'b0, 3'd0, 2'd1, 64'h11223344, 20'h00067, 8'h89, 4'h0},
    '{16'h007F, 1'b0, 3'd0, 2'd1, 64'h00400000, 20'h000FF, 8'h82, 4'h0},
    '{16'h0078, 1'b1, 3'd2, 2'd1, 64'h0, 20'h0, 8'h0, 4'h0},
    '{16'h0080, 1'b0, 3'd2, 2'd0, 64'h0, 20'h0, 8'h0, 4'h0},
    '{16'h000B, 1'b0, 3'd0, 2'd1, 64'h12345678, 20'hABCDE, 8'h9B, 4'hC}
  };

  function automatic string ftag(logic [2:0] f);
    case (f)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", 64'(req_ready), 64'd1);
    chk("R1 mem_valid", 64'(mem_valid), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    rst_n = 1;
    load_tbl(TBASE, 16'd127);

    foreach (VECS[i]) begin
      stall_n = i % 3;
      run(VECS[i].sel, VECS[i].lng);
      chk({ftag(VECS[i].flt), " fault"}, 64'(r_flt), 64'(VECS[i].flt));
      chk("R2 reads", 64'(rd_cnt), 64'(VECS[i].nrd));
      if (VECS[i].flt == 3'd0) begin
        chk(VECS[i].lng ? "R8 base" : "R5 base", r_base, VECS[i].base);
        chk("R5 limit", 64'(r_lim), 64'(VECS[i].lim));
        chk("R5 access", 64'(r_acc), 64'(VECS[i].acc));
        chk("R5 flags", 64'(r_flg), 64'(VECS[i].flg));
      end
    end

    // R9 only entry 2 was written back, with accessed bit set in memory
    chk("R9 write count", 64'(wr_cnt), 64'd1);
    chk("R9 mem entry", mem[2], mk(32'hCAFEBABE, 20'h0F0F0, 8'h93, 4'h4));
    chk("R9 system untouched", mem[15], mk(32'h00400000, 20'h000FF, 8'h82, 4'h0));

    // R8 second word address
    stall_n = 1;
    run(16'h0030, 1'b1);
    chk("R8 first addr", 64'(rd_addr[0]), 64'h1030);
    chk("R8 second addr", 64'(rd_addr[1]), 64'h1038);

    // R10 refused write-back
    refuse = 1;
    run(16'h0040, 1'b0);
    chk("R10 fault", 64'(r_flt), 64'd5);
    chk("R10 mem unchanged", mem[8], mk(32'h00ABCDEF, 20'h00010, 8'h92, 4'h4));
    refuse = 0;
    run(16'h0040, 1'b0);
    chk("R9 retry fault", 64'(r_flt), 64'd0);
    chk("R9 retry access", 64'(r_acc), 64'h93);

    // R4 boundary with a two-entry table
    load_tbl(TBASE, 16'd15);
    run(16'h0008, 1'b0);
    chk("R4 last entry fits", 64'(r_flt), 64'd0);
    run(16'h0010, 1'b0);
    chk("R4 past end", 64'(r_flt), 64'd2);
    chk("R4 no read", 64'(rd_cnt), 64'd0);

    // R2 new base shifts the entry address
    load_tbl(TBASE + 32'd8, 16'd127);
    run(16'h0008, 1'b0);
    chk("R2 rebased addr", 64'(rd_addr[0]), 64'h1010);
    chk("R2 rebased base", r_base, 64'hCAFEBABE);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule